// File: doc/BRIEF.md
# Multicycle Load Controller with Post-Increment

This block is a small multicycle datapath with its controller. It executes two load instructions from a single memory port that serves both instruction fetch and data reads. The ordinary word load writes `mem[rs + sext(imm)]` into register rt. The post-increment load does the same and also replaces base register rs with `rs + 4`. This lets a loop walk a word array with one instruction per element instead of a load followed by a separate add.

The datapath holds a program counter, an instruction register, two operand registers, an ALU result register and a memory data register. It also contains a 32-entry register file. Instructions run as a fixed series of states: fetch, decode, address, memory, then write-back. During the memory state the post-increment load uses the otherwise idle ALU to form base + 4. It then spends one extra write-back state, which writes that sum through a three-way destination select. The conventional control signals and the register-file write port are brought out on the ports, so the block's progress can be observed cycle by cycle.

Top module: `pil_core`

## Requirements
- R1: While reset is held, `cur_state` reads 0 (fetch), `mem_addr` equals the reset PC (0), and `rf_we` is low.
- R2: In fetch (`cur_state`=0), `mem_rd`=1 and `ctl_iord`=0, so `mem_addr` equals the PC. The instruction word is captured, and the next instruction is fetched from PC+4.
- R3: An ordinary load (opcode IR[31:26]=100011, rs=IR[25:21], rt=IR[20:16], imm=IR[15:0]) takes five cycles with `cur_state` 0,1,2,3,4 and then returns to 0. In state 3, `mem_rd`=1, `ctl_iord`=1 and `mem_addr` = rs value + sign-extended imm. Memory words are selected by address bits [31:2].
- R4: A negative immediate (imm[15]=1) is sign-extended, so the effective address lies below the base.
- R5: In state 4, `rf_we`=1, `rf_waddr`=rt, `rf_wdata` = the word read in state 3, `ctl_reg_dst`=00 and `ctl_mem_to_reg`=1. The register then holds that word for later reads.
- R6: For a post-increment load (opcode 111111), state 3 drives `ctl_alu_src_a`=1, `ctl_alu_src_b`=01 (constant 4) and `ctl_alu_op`=00 (add), together with the memory read.
- R7: A post-increment load follows state 4 with state 13. In state 13, `rf_we`=1, `rf_waddr`=rs, `rf_wdata` = original rs value + 4, `ctl_reg_dst`=10 (IR[25:21]) and `ctl_mem_to_reg`=0. It then returns to state 0, for six cycles in total.
- R8: Any other opcode goes from decode straight back to fetch of the next word, with no register write. The instruction takes two cycles.
- R9: Register 0 always reads as zero. Writes addressed to it have no effect.
- R10: When a post-increment load names the same register as rs and rt, the state-13 write comes last, so the register ends as the original base + 4.
- R11: Fetch drives ALU source A=0, B=01, op=00. Decode drives A=0, B=11. The address state drives A=1, B=10, op=00, with no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 32 | Byte address to the shared memory |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| ctl_iord | output | 1 | Address source: 0 = PC, 1 = ALU result register |
| ctl_alu_src_a | output | 1 | ALU A source: 0 = PC, 1 = A register |
| ctl_alu_src_b | output | 2 | ALU B source: 00 = B, 01 = 4, 10 = sext imm, 11 = sext imm << 2 |
| ctl_alu_op | output | 2 | ALU operation: 00 = add, 01 = subtract |
| ctl_reg_dst | output | 2 | Destination select: 00 = IR[20:16], 01 = IR[15:11], 10 = IR[25:21] |
| ctl_mem_to_reg | output | 1 | Write-data source: 1 = memory data register, 0 = ALU result register |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write address |
| rf_wdata | output | 32 | Register-file write data |
| cur_state | output | 4 | Current state number (0,1,2,3,4,13) |

## Verification
A wrong next-state decision shows up on `cur_state` and on the strobes in the very next cycle. Examples are a missing state 13, an extra state for an undefined opcode, or a skipped address state. A corrupted PC or base register is less direct: it appears one instruction later, as a wrong `mem_addr` in that instruction's fetch or memory cycle. For that reason the directed programs chain each load's result into the base of a later load. A lost ALU result between state 3 and state 13 appears on `rf_wdata` two cycles after the memory read. A write leaking into register 0 appears as a shifted data address in the next load based on register 0.

// File: rtl/pil_pkg.sv
package pil_pkg;

  localparam int XLEN = 32;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_LOAD    = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_LOAD_PI = 6'b111111;

  // state numbers are visible on cur_state
  typedef enum logic [3:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_ADDR    = 4'd2,
    ST_MEM     = 4'd3,
    ST_WB_MEM  = 4'd4,
    ST_WB_BASE = 4'd13
  } pil_state_e;

  typedef struct packed {
    logic       mem_rd;
    logic       iord;
    logic       ir_we;
    logic       pc_we;
    logic       ab_we;
    logic       res_we;
    logic       mdr_we;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic [1:0] alu_op;
    logic [1:0] reg_dst;
    logic       mem_to_reg;
    logic       reg_we;
  } pil_ctl_t;

  function automatic logic [XLEN-1:0] sext16(input logic [15:0] imm);
    return {{(XLEN-16){imm[15]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input logic [1:0] op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    return (op == 2'b01) ? (a - b) : (a + b);
  endfunction

  function automatic logic is_load_op(input logic [OPC_W-1:0] opc);
    return (opc == OPC_LOAD) || (opc == OPC_LOAD_PI);
  endfunction

endpackage

// File: rtl/pil_ctrl.sv
module pil_ctrl
  import pil_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output pil_state_e       state,
  output pil_ctl_t         ctl
);

  pil_state_e state_nx;
  logic       is_pi;

  assign is_pi = (opcode == OPC_LOAD_PI);

  always_comb begin
    state_nx = ST_FETCH;
    unique case (state)
      ST_FETCH:   state_nx = ST_DECODE;
      ST_DECODE:  state_nx = is_load_op(opcode) ? ST_ADDR : ST_FETCH;
      ST_ADDR:    state_nx = ST_MEM;
      ST_MEM:     state_nx = ST_WB_MEM;
      ST_WB_MEM:  state_nx = is_pi ? ST_WB_BASE : ST_FETCH;
      ST_WB_BASE: state_nx = ST_FETCH;
      default:    state_nx = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= state_nx;
  end

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_we     = 1'b1;
        ctl.pc_we     = 1'b1;
        ctl.alu_src_b = 2'b01;
      end
      ST_DECODE: begin
        ctl.ab_we     = 1'b1;
        ctl.res_we    = 1'b1;
        ctl.alu_src_b = 2'b11;
      end
      ST_ADDR: begin
        ctl.res_we    = 1'b1;
        ctl.alu_src_a = 1'b1;
        ctl.alu_src_b = 2'b10;
      end
      ST_MEM: begin
        ctl.mem_rd = 1'b1;
        ctl.iord   = 1'b1;
        ctl.mdr_we = 1'b1;
        if (is_pi) begin
          ctl.res_we    = 1'b1;
          ctl.alu_src_a = 1'b1;
          ctl.alu_src_b = 2'b01;
        end
      end
      ST_WB_MEM: begin
        ctl.reg_we     = 1'b1;
        ctl.mem_to_reg = 1'b1;
        ctl.reg_dst    = 2'b00;
      end
      ST_WB_BASE: begin
        ctl.reg_we  = 1'b1;
        ctl.reg_dst = 2'b10;
      end
      default: ctl = '0;
    endcase
  end

  assert_base_wb_follows_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WB_BASE |-> $past(state) == ST_WB_MEM);
  assert_undefined_back_to_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE && !is_load_op(opcode)) |=> state == ST_FETCH);
  assert_read_only_fetch_or_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.mem_rd |-> (state == ST_FETCH || state == ST_MEM));
  assert_no_write_during_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.reg_we |-> !ctl.mem_rd);

endmodule

// File: rtl/pil_regfile.sv
module pil_regfile #(
  parameter int W = 32,
  parameter int N = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] raddr_a,
  input  logic [$clog2(N)-1:0] raddr_b,
  output logic [W-1:0]         rdata_a,
  output logic [W-1:0]         rdata_b
);

  localparam int AW = $clog2(N);

  logic [W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign regs[i] = '0;
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (!rst_n)                          regs[i] <= '0;
        else if (we && waddr == AW'(i))      regs[i] <= wdata;
      end
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != '0) |=> regs[$past(waddr)] == $past(wdata));
  assert_zero_reg_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == '0) |=> rdata_a == '0 || raddr_a != '0);

endmodule

// File: rtl/pil_datapath.sv
module pil_datapath
  import pil_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter int              REG_AW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pil_ctl_t          ctl,
  input  logic [XLEN-1:0]   mem_rdata,
  input  logic [XLEN-1:0]   rf_rdata_a,
  input  logic [XLEN-1:0]   rf_rdata_b,
  output logic [XLEN-1:0]   mem_addr,
  output logic [OPC_W-1:0]  opcode,
  output logic [REG_AW-1:0] rf_raddr_a,
  output logic [REG_AW-1:0] rf_raddr_b,
  output logic [REG_AW-1:0] rf_waddr,
  output logic [XLEN-1:0]   rf_wdata
);

  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, res_q, mdr_q;
  logic [XLEN-1:0] alu_a, alu_b, alu_res, imm_ext;
  logic [REG_AW-1:0] f_rs, f_rt, f_rd;

  assign opcode  = ir_q[31:26];
  assign f_rs    = ir_q[21 +: REG_AW];
  assign f_rt    = ir_q[16 +: REG_AW];
  assign f_rd    = ir_q[11 +: REG_AW];
  assign imm_ext = sext16(ir_q[15:0]);

  assign rf_raddr_a = f_rs;
  assign rf_raddr_b = f_rt;

  assign alu_a = ctl.alu_src_a ? a_q : pc_q;
  always_comb begin
    unique case (ctl.alu_src_b)
      2'b00:   alu_b = b_q;
      2'b01:   alu_b = XLEN'(4);
      2'b10:   alu_b = imm_ext;
      default: alu_b = imm_ext << 2;
    endcase
  end
  assign alu_res = alu_eval(ctl.alu_op, alu_a, alu_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
      mdr_q <= '0;
    end else begin
      if (ctl.pc_we)  pc_q  <= alu_res;
      if (ctl.ir_we)  ir_q  <= mem_rdata;
      if (ctl.ab_we) begin
        a_q <= rf_rdata_a;
        b_q <= rf_rdata_b;
      end
      if (ctl.res_we) res_q <= alu_res;
      if (ctl.mdr_we) mdr_q <= mem_rdata;
    end
  end

  assign mem_addr = ctl.iord ? res_q : pc_q;

  always_comb begin
    unique case (ctl.reg_dst)
      2'b00:   rf_waddr = f_rt;
      2'b01:   rf_waddr = f_rd;
      2'b10:   rf_waddr = f_rs;
      default: rf_waddr = f_rt;
    endcase
  end
  assign rf_wdata = ctl.mem_to_reg ? mdr_q : res_q;

  assert_pc_steps_by_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_we |=> pc_q == $past(pc_q) + XLEN'(4));
  assert_base_plus_four_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.reg_we && ctl.reg_dst == 2'b10) |-> rf_wdata == a_q + XLEN'(4));
  assert_ir_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.ir_we |=> $stable(ir_q));

endmodule

// File: rtl/pil_core.sv
module pil_core
  import pil_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter int          REG_CNT  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] mem_addr,
  output logic        mem_rd,
  input  logic [31:0] mem_rdata,
  output logic        ctl_iord,
  output logic        ctl_alu_src_a,
  output logic [1:0]  ctl_alu_src_b,
  output logic [1:0]  ctl_alu_op,
  output logic [1:0]  ctl_reg_dst,
  output logic        ctl_mem_to_reg,
  output logic        rf_we,
  output logic [4:0]  rf_waddr,
  output logic [31:0] rf_wdata,
  output logic [3:0]  cur_state
);

  localparam int REG_AW = $clog2(REG_CNT);

  pil_state_e         state;
  pil_ctl_t           ctl;
  logic [OPC_W-1:0]   opcode;
  logic [REG_AW-1:0]  raddr_a, raddr_b, waddr;
  logic [XLEN-1:0]    rdata_a, rdata_b;

  pil_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opcode (opcode),
    .state  (state),
    .ctl    (ctl)
  );

  pil_datapath #(.RESET_PC(RESET_PC), .REG_AW(REG_AW)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .mem_rdata  (mem_rdata),
    .rf_rdata_a (rdata_a),
    .rf_rdata_b (rdata_b),
    .mem_addr   (mem_addr),
    .opcode     (opcode),
    .rf_raddr_a (raddr_a),
    .rf_raddr_b (raddr_b),
    .rf_waddr   (waddr),
    .rf_wdata   (rf_wdata)
  );

  pil_regfile #(.W(XLEN), .N(REG_CNT)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ctl.reg_we),
    .waddr   (waddr),
    .wdata   (rf_wdata),
    .raddr_a (raddr_a),
    .raddr_b (raddr_b),
    .rdata_a (rdata_a),
    .rdata_b (rdata_b)
  );

  assign mem_rd         = ctl.mem_rd;
  assign ctl_iord       = ctl.iord;
  assign ctl_alu_src_a  = ctl.alu_src_a;
  assign ctl_alu_src_b  = ctl.alu_src_b;
  assign ctl_alu_op     = ctl.alu_op;
  assign ctl_reg_dst    = ctl.reg_dst;
  assign ctl_mem_to_reg = ctl.mem_to_reg;
  assign rf_we          = ctl.reg_we;
  assign rf_waddr       = waddr;
  assign cur_state      = state;

  assert_data_read_uses_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && cur_state == 4'd3) |-> ctl_iord);
  assert_postinc_alu_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 4'd3 && opcode == OPC_LOAD_PI) |-> (ctl_alu_src_a && ctl_alu_src_b == 2'b01 && ctl_alu_op == 2'b00));

endmodule

// File: tb/pil_core_bench.sv
module pil_core_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_rdata, rf_wdata;
  logic        mem_rd, ctl_iord, ctl_alu_src_a, ctl_mem_to_reg, rf_we;
  logic [1:0]  ctl_alu_src_b, ctl_alu_op, ctl_reg_dst;
  logic [4:0]  rf_waddr;
  logic [3:0]  cur_state;

  logic [31:0] mem [128];
  logic [31:0] mreg [32];
  logic [31:0] pc_m;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[8:2]];

  pil_core u_pil_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .ctl_iord(ctl_iord), .ctl_alu_src_a(ctl_alu_src_a), .ctl_alu_src_b(ctl_alu_src_b),
    .ctl_alu_op(ctl_alu_op), .ctl_reg_dst(ctl_reg_dst), .ctl_mem_to_reg(ctl_mem_to_reg),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .cur_state(cur_state)
  );

  function automatic logic [31:0] enc(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // runs one instruction starting at the negedge of its fetch cycle
  task automatic exec_one();
    logic [31:0] ins, base, ea, dat;
    logic [5:0]  op;
    int rs, rt;
    bit pi, valid;
    ins   = mem[pc_m[8:2]];
    op    = ins[31:26];
    rs    = int'(ins[25:21]);
    rt    = int'(ins[20:16]);
    pi    = (op == 6'b111111);
    valid = pi || (op == 6'b100011);
    base  = mreg[rs];
    ea    = base + {{16{ins[15]}}, ins[15:0]};
    dat   = mem[ea[8:2]];
    // fetch
    chk("R2 state", 32'(cur_state), 32'd0);
    chk("R2 rd/iord", {30'd0, mem_rd, ctl_iord}, 32'b10);
    chk("R2 addr", mem_addr, pc_m);
    chk("R11 fetch alu", {27'd0, ctl_alu_src_a, ctl_alu_src_b, ctl_alu_op}, 32'b00100);
    chk("R2 no write", 32'(rf_we), 32'd0);
    @(negedge clk); pc_m += 4;
    chk("R3 decode state", 32'(cur_state), 32'd1);
    chk("R11 decode alu", {28'd0, ctl_alu_src_a, ctl_alu_src_b, mem_rd}, 32'b0110);
    chk("R8 decode no write", 32'(rf_we), 32'd0);
    @(negedge clk);
    if (!valid) begin
      chk("R8 back to fetch", 32'(cur_state), 32'd0);
      chk("R8 next addr", mem_addr, pc_m);
      return;
    end
    chk("R3 addr state", 32'(cur_state), 32'd2);
    chk("R11 addr alu", {27'd0, ctl_alu_src_a, ctl_alu_src_b, ctl_alu_op}, 32'b11000);
    chk("R11 addr no read", 32'(mem_rd), 32'd0);
    @(negedge clk);
    chk("R3 mem state", 32'(cur_state), 32'd3);
    chk("R3 rd/iord", {30'd0, mem_rd, ctl_iord}, 32'b11);
    chk("R3 R4 data addr", mem_addr, ea);
    if (pi) chk("R6 overlap alu", {27'd0, ctl_alu_src_a, ctl_alu_src_b, ctl_alu_op}, 32'b10100);
    @(negedge clk);
    chk("R5 wb state", 32'(cur_state), 32'd4);
    chk("R5 we", 32'(rf_we), 32'd1);
    chk("R5 waddr", 32'(rf_waddr), 32'(rt));
    chk("R5 wdata", rf_wdata, dat);
    chk("R5 dst/m2r", {29'd0, ctl_reg_dst, ctl_mem_to_reg}, 32'b001);
    if (rt != 0) mreg[rt] = dat;
    @(negedge clk);
    if (pi) begin
      chk("R7 state", 32'(cur_state), 32'd13);
      chk("R7 we", 32'(rf_we), 32'd1);
      chk("R7 waddr", 32'(rf_waddr), 32'(rs));
      chk("R7 wdata", rf_wdata, base + 32'd4);
      chk("R7 dst/m2r", {29'd0, ctl_reg_dst, ctl_mem_to_reg}, 32'b100);
      if (rs != 0) mreg[rs] = base + 32'd4;
      @(negedge clk);
    end
    chk("R3 return to fetch", 32'(cur_state), 32'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 state", 32'(cur_state), 32'd0);
    chk("R1 addr", mem_addr, 32'd0);
    chk("R1 no write", 32'(rf_we), 32'd0);
    rst_n = 1'b1;
    pc_m = 32'd0;
  endtask

  task automatic t_plain_loads();   // R3 R5: fill r1, r2
    exec_one(); exec_one();
  endtask
  task automatic t_postinc();       // R6 R7
    exec_one();
    chk("R7 base advanced", mreg[1], 32'h104);
  endtask
  task automatic t_neg_offset();    // R4
    exec_one();
  endtask
  task automatic t_undefined();     // R8
    exec_one();
  endtask
  task automatic t_same_reg();      // R10: following load uses base+4
    exec_one();
    chk("R10 final value", mreg[1], 32'h108);
    exec_one();
  endtask
  task automatic t_zero_reg();      // R9: write to r0 then r0-based loads
    exec_one(); exec_one(); exec_one(); exec_one();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'd0;
    for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    mem[0]  = enc(6'b100011, 0, 1, 16'h0080);
    mem[1]  = enc(6'b100011, 0, 2, 16'h0084);
    mem[2]  = enc(6'b111111, 1, 3, 16'h0008);
    mem[3]  = enc(6'b100011, 1, 4, 16'hfffc);
    mem[4]  = 32'h0000_0000;
    mem[5]  = enc(6'b111111, 1, 1, 16'h0000);
    mem[6]  = enc(6'b100011, 1, 6, 16'h0000);
    mem[7]  = enc(6'b100011, 0, 0, 16'h0084);
    mem[8]  = enc(6'b100011, 0, 7, 16'h0080);
    mem[9]  = enc(6'b111111, 0, 8, 16'h0080);
    mem[10] = enc(6'b100011, 0, 9, 16'h0084);
    mem[32] = 32'h0000_0100;
    mem[33] = 32'hdead_beef;
    mem[64] = 32'h3333_4444;
    mem[65] = 32'h5555_6666;
    mem[66] = 32'h1111_2222;
    t_reset();
    t_plain_loads();
    t_postinc();
    t_neg_offset();
    t_undefined();
    t_same_reg();
    t_zero_reg();
    chk("R9 r0 stays zero", mreg[0], 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule